// File: doc/BRIEF.md
# TDM Audio Frame Serializer

This block is the transmit engine of a serial audio port running as timing master. A clock generator upstream supplies two single-cycle pulses per bit period, one for each bit clock edge. On every pulse of the selected edge the engine drives one bit of a frame. It drives the frame sync line and serial data, and it takes PCM words from a small FIFO through a valid/ready pair. The words go out MSB-first into a programmable set of time slots.

The frame length, the sync width, polarity and one-bit-early option, the slot count and width, the slot enable mask, the data placement inside a slot and a mono duplication mode are all run-time inputs. With these one engine produces I2S, left- and right-justified and DSP-style short-sync framing, with two or more TDM slots. The configuration is captured only while the engine is idle. Once the enable drops, the frame in progress runs to its end before the engine goes quiet.

Top module: `tdm_serializer`

## Requirements
- R1: A frame lasts `cfg_frame_last`+1 launch ticks. Slot 0 starts at the first data bit of the frame. Without the early option, frame sync is active on the first `cfg_sync_last`+1 bits of the frame, starting with the first bit of slot 0.
- R2: With `cfg_sync_early`=1, sync goes active one tick before the first bit of slot 0 and stays active for `cfg_sync_last`+1 ticks in total. The first frame after a start is preceded by one lead-in tick that carries sync and a zero data bit. No sync is raised after the last bit of the final frame.
- R3: `cfg_sync_high`=1 makes frame sync active high. A value of 0 makes it active low. When idle, the line rests at its inactive level.
- R4: `cfg_launch_fall`=0 advances the engine on `rise_tick`, and 1 advances it on `fall_tick`. Outputs change only on the clock cycle after a selected tick. The other tick has no effect.
- R5: A frame holds `cfg_slot_last`+1 slots. The slot width code is 0 = data size, 1 = 16 bits, 2 = 32 bits. The data size code is 2 = 8, 3 = 10, 4 = 16, 5 = 20, 6 = 24, 7 = 32 bits. The sample sits in the low data-size bits of `word_data` and is sent MSB-first. Bits of the frame past the last slot are 0.
- R6: Only slots whose bit is set in `cfg_slot_mask` (bit n for slot n) carry data and take a FIFO word. A masked slot sends zeros and takes none.
- R7: The sample starts `cfg_first_off` bits into its slot. All other bits of an enabled slot are 0.
- R8: With `cfg_mono`=1 and two slots, slot 1 repeats the word sent in slot 0 without taking a new FIFO word.
- R9: If an enabled slot needs a word while `word_valid` is low, that slot sends zeros. `underrun` pulses for exactly one cycle, aligned with the slot's first bit.
- R10: A data size code outside 2..7, slot width code 3, or a data size wider than the slot is rejected. `cfg_bad` is high, the engine never starts and no word is taken.
- R11: Configuration changes made while a frame sequence is running do not affect it. After `enable` falls, the current frame completes and the engine stops.
- R12: `word_ready` is high only in a cycle with a selected tick in which an enabled slot starts and takes a new word. A word is taken when `word_ready` and `word_valid` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run request |
| rise_tick | input | 1 | Bit clock rising edge pulse |
| fall_tick | input | 1 | Bit clock falling edge pulse |
| cfg_frame_last | input | 9 | Frame length minus one, in bits |
| cfg_sync_last | input | 9 | Sync active length minus one |
| cfg_sync_early | input | 1 | Raise sync one bit before slot 0 |
| cfg_sync_high | input | 1 | Sync active high when 1 |
| cfg_launch_fall | input | 1 | Launch data on the falling tick |
| cfg_slot_last | input | 4 | Slot count minus one |
| cfg_slot_code | input | 2 | Slot width code |
| cfg_slot_mask | input | 16 | Per-slot enable |
| cfg_first_off | input | 5 | Bit offset of the sample in its slot |
| cfg_size_code | input | 3 | Data size code |
| cfg_mono | input | 1 | Repeat slot 0 word in slot 1 |
| word_data | input | 32 | Sample word, right-aligned |
| word_valid | input | 1 | FIFO holds a word |
| word_ready | output | 1 | Word taken this cycle |
| ser_data | output | 1 | Serial data |
| frame_sync | output | 1 | Frame sync |
| underrun | output | 1 | One-cycle pulse when a word was missing |
| cfg_bad | output | 1 | Captured configuration is illegal |

## Verification
A wrong bit or slot counter shows on the first tick after it goes astray. Sync then rises on the wrong bit, or data lands one bit off, and the whole rest of the frame miscompares. A slip in the word register or the fetch decision has a different signature. Every later slot carries the wrong sample, and the count of taken words at the end of the run disagrees with the expected count. A faulty config capture or run control shows up as sync or data activity in the idle ticks after the final frame, or as a run that starts on an illegal configuration.

// File: rtl/tdm_ser_pkg.sv
package tdm_ser_pkg;

    parameter int WORD_W     = 32;
    parameter int SLOT_MAX   = 16;
    parameter int FRAME_W    = 9;
    localparam int BIT_W      = $clog2(WORD_W);
    localparam int LEN_W      = BIT_W + 1;
    localparam int SLOT_IDX_W = $clog2(SLOT_MAX);
    localparam int SLOT_CNT_W = SLOT_IDX_W + 1;

    typedef struct packed {
        logic [FRAME_W-1:0]    frame_last;
        logic [FRAME_W-1:0]    sync_last;
        logic                  sync_early;
        logic                  sync_high;
        logic                  launch_fall;
        logic [SLOT_IDX_W-1:0] slot_last;
        logic [1:0]            slot_code;
        logic [SLOT_MAX-1:0]   slot_mask;
        logic [BIT_W-1:0]      first_off;
        logic [2:0]            size_code;
        logic                  mono;
    } tdm_cfg_t;

    // Sample width in bits for a size code; 0 marks an illegal code.
    function automatic logic [LEN_W-1:0] data_bits(input logic [2:0] code);
        case (code)
            3'd2:    return LEN_W'(8);
            3'd3:    return LEN_W'(10);
            3'd4:    return LEN_W'(16);
            3'd5:    return LEN_W'(20);
            3'd6:    return LEN_W'(24);
            3'd7:    return LEN_W'(32);
            default: return '0;
        endcase
    endfunction

    // Slot width in bits; 0 marks an illegal code.
    function automatic logic [LEN_W-1:0] slot_bits(input logic [1:0] code,
                                                   input logic [LEN_W-1:0] ds);
        case (code)
            2'd0:    return ds;
            2'd1:    return LEN_W'(16);
            2'd2:    return LEN_W'(32);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/tdm_cfg_hold.sv
module tdm_cfg_hold
    import tdm_ser_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     hold,
    input  tdm_cfg_t cfg_in,
    output tdm_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q           <= '0;
            cfg_q.sync_high <= 1'b1;
        end else if (!hold) begin
            cfg_q <= cfg_in;
        end
    end

endmodule

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
    import tdm_ser_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  enable,
    input  logic                  rise_tick,
    input  logic                  fall_tick,
    input  logic                  cfg_ok,
    input  logic [FRAME_W-1:0]    frame_last,
    input  logic [FRAME_W-1:0]    sync_last,
    input  logic                  sync_early,
    input  logic                  sync_high,
    input  logic                  launch_fall,
    input  logic [LEN_W-1:0]      slot_w,
    output logic                  tick,
    output logic                  act,
    output logic                  running,
    output logic                  lead,
    output logic [SLOT_CNT_W-1:0] slot,
    output logic [BIT_W-1:0]      bis,
    output logic                  fs_pin
);

    logic [FRAME_W-1:0] bitpos;
    logic               start;
    logic               last_pos;
    logic               fs_now;
    logic               fs_act;

    always_comb begin
        tick     = launch_fall ? fall_tick : rise_tick;
        start    = !running && enable && cfg_ok && tick;
        act      = tick && (running || start);
        last_pos = (bitpos == frame_last);
        if (sync_early)
            fs_now = (last_pos && (lead || enable)) || (!lead && (bitpos < sync_last));
        else
            fs_now = (bitpos <= sync_last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            lead    <= 1'b0;
            bitpos  <= '0;
            slot    <= '0;
            bis     <= '0;
            fs_act  <= 1'b0;
        end else begin
            if (act)
                fs_act <= fs_now;
            else if (tick)
                fs_act <= 1'b0;

            if (act) begin
                if (last_pos) begin
                    bis  <= '0;
                    slot <= '0;
                    if (!lead && !enable) begin
                        running <= 1'b0;
                        lead    <= sync_early;
                        bitpos  <= sync_early ? frame_last : '0;
                    end else begin
                        running <= 1'b1;
                        lead    <= 1'b0;
                        bitpos  <= '0;
                    end
                end else begin
                    running <= 1'b1;
                    bitpos  <= bitpos + FRAME_W'(1);
                    if ({1'b0, bis} == slot_w - LEN_W'(1)) begin
                        bis <= '0;
                        if (slot != SLOT_CNT_W'(SLOT_MAX))
                            slot <= slot + SLOT_CNT_W'(1);
                    end else begin
                        bis <= bis + BIT_W'(1);
                    end
                end
            end else if (!running) begin
                lead   <= sync_early;
                bitpos <= sync_early ? frame_last : '0;
                slot   <= '0;
                bis    <= '0;
            end
        end
    end

    assign fs_pin = sync_high ? fs_act : !fs_act;

endmodule

// File: rtl/tdm_slot_feeder.sv
module tdm_slot_feeder
    import tdm_ser_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic                  act,
    input  logic                  lead,
    input  logic [SLOT_CNT_W-1:0] slot,
    input  logic [BIT_W-1:0]      bis,
    input  logic [SLOT_IDX_W-1:0] slot_last,
    input  logic [SLOT_MAX-1:0]   slot_mask,
    input  logic [BIT_W-1:0]      first_off,
    input  logic [LEN_W-1:0]      ds,
    input  logic                  mono,
    input  logic [WORD_W-1:0]     word_data,
    input  logic                  word_valid,
    output logic                  word_ready,
    output logic                  ser_data,
    output logic                  underrun
);

    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] fresh;
    logic [WORD_W-1:0] cur;
    logic              slot_on;
    logic              first;
    logic              reuse;
    logic              want;
    logic              inwin;
    logic [LEN_W-1:0]  rel;
    logic [LEN_W-1:0]  idx;
    logic              bit_now;

    always_comb begin
        slot_on = !lead && (slot <= {1'b0, slot_last}) && slot_mask[slot[SLOT_IDX_W-1:0]];
        first   = slot_on && (bis == '0);
        reuse   = mono && (slot_last == SLOT_IDX_W'(1)) && (slot == SLOT_CNT_W'(1));
        want    = act && first && !reuse;
        fresh   = word_valid ? word_data : '0;
        cur     = (first && !reuse) ? fresh : word_q;
        rel     = {1'b0, bis} - {1'b0, first_off};
        inwin   = (bis >= first_off) && (rel < ds);
        idx     = ds - LEN_W'(1) - rel;
        bit_now = slot_on && inwin && cur[idx[BIT_W-1:0]];
    end

    assign word_ready = want;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q   <= '0;
            ser_data <= 1'b0;
            underrun <= 1'b0;
        end else begin
            if (want)
                word_q <= fresh;
            underrun <= want && !word_valid;
            if (act)
                ser_data <= bit_now;
            else if (tick)
                ser_data <= 1'b0;
        end
    end

endmodule

// File: rtl/tdm_serializer.sv
module tdm_serializer
    import tdm_ser_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  enable,
    input  logic                  rise_tick,
    input  logic                  fall_tick,
    input  logic [FRAME_W-1:0]    cfg_frame_last,
    input  logic [FRAME_W-1:0]    cfg_sync_last,
    input  logic                  cfg_sync_early,
    input  logic                  cfg_sync_high,
    input  logic                  cfg_launch_fall,
    input  logic [SLOT_IDX_W-1:0] cfg_slot_last,
    input  logic [1:0]            cfg_slot_code,
    input  logic [SLOT_MAX-1:0]   cfg_slot_mask,
    input  logic [BIT_W-1:0]      cfg_first_off,
    input  logic [2:0]            cfg_size_code,
    input  logic                  cfg_mono,
    input  logic [WORD_W-1:0]     word_data,
    input  logic                  word_valid,
    output logic                  word_ready,
    output logic                  ser_data,
    output logic                  frame_sync,
    output logic                  underrun,
    output logic                  cfg_bad
);

    tdm_cfg_t              cfg_live;
    tdm_cfg_t              cfg;
    logic [LEN_W-1:0]      ds;
    logic [LEN_W-1:0]      sw;
    logic                  ok;
    logic                  tick;
    logic                  act;
    logic                  running;
    logic                  lead;
    logic [SLOT_CNT_W-1:0] slot;
    logic [BIT_W-1:0]      bis;

    always_comb begin
        cfg_live.frame_last  = cfg_frame_last;
        cfg_live.sync_last   = cfg_sync_last;
        cfg_live.sync_early  = cfg_sync_early;
        cfg_live.sync_high   = cfg_sync_high;
        cfg_live.launch_fall = cfg_launch_fall;
        cfg_live.slot_last   = cfg_slot_last;
        cfg_live.slot_code   = cfg_slot_code;
        cfg_live.slot_mask   = cfg_slot_mask;
        cfg_live.first_off   = cfg_first_off;
        cfg_live.size_code   = cfg_size_code;
        cfg_live.mono        = cfg_mono;
        ds = data_bits(cfg.size_code);
        sw = slot_bits(cfg.slot_code, ds);
        ok = (ds != '0) && (sw != '0) && (ds <= sw);
    end

    assign cfg_bad = !ok;

    tdm_cfg_hold u_hold (
        .clk    (clk),
        .rst    (rst),
        .hold   (running),
        .cfg_in (cfg_live),
        .cfg_q  (cfg)
    );

    tdm_frame_timer u_timer (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .rise_tick   (rise_tick),
        .fall_tick   (fall_tick),
        .cfg_ok      (ok),
        .frame_last  (cfg.frame_last),
        .sync_last   (cfg.sync_last),
        .sync_early  (cfg.sync_early),
        .sync_high   (cfg.sync_high),
        .launch_fall (cfg.launch_fall),
        .slot_w      (sw),
        .tick        (tick),
        .act         (act),
        .running     (running),
        .lead        (lead),
        .slot        (slot),
        .bis         (bis),
        .fs_pin      (frame_sync)
    );

    tdm_slot_feeder u_feed (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .act        (act),
        .lead       (lead),
        .slot       (slot),
        .bis        (bis),
        .slot_last  (cfg.slot_last),
        .slot_mask  (cfg.slot_mask),
        .first_off  (cfg.first_off),
        .ds         (ds),
        .mono       (cfg.mono),
        .word_data  (word_data),
        .word_valid (word_valid),
        .word_ready (word_ready),
        .ser_data   (ser_data),
        .underrun   (underrun)
    );

endmodule

// File: rtl/tdm_serializer_checker.sv
module tdm_serializer_checker (
    input logic clk,
    input logic rst,
    input logic rise_tick,
    input logic fall_tick,
    input logic word_ready,
    input logic word_valid,
    input logic underrun,
    input logic ser_data,
    input logic cfg_bad
);

    p_ready_on_tick_r12: assert property (@(posedge clk) disable iff (rst)
        word_ready |-> (rise_tick || fall_tick));

    p_underrun_cause_r9: assert property (@(posedge clk) disable iff (rst)
        underrun |-> $past(word_ready && !word_valid));

    p_bad_no_fetch_r10: assert property (@(posedge clk) disable iff (rst)
        cfg_bad |-> !word_ready);

    p_data_steady_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(rise_tick || fall_tick) |-> $stable(ser_data));

endmodule

bind tdm_serializer tdm_serializer_checker u_chk (.*);

// File: tb/tdm_serializer_test.sv
module tdm_serializer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        rise_tick = 1'b0;
    logic        fall_tick = 1'b0;
    logic [8:0]  cfg_frame_last = '0;
    logic [8:0]  cfg_sync_last = '0;
    logic        cfg_sync_early = 1'b0;
    logic        cfg_sync_high = 1'b1;
    logic        cfg_launch_fall = 1'b0;
    logic [3:0]  cfg_slot_last = '0;
    logic [1:0]  cfg_slot_code = '0;
    logic [15:0] cfg_slot_mask = '0;
    logic [4:0]  cfg_first_off = '0;
    logic [2:0]  cfg_size_code = '0;
    logic        cfg_mono = 1'b0;
    logic [31:0] word_data;
    logic        word_valid;
    logic        word_ready;
    logic        ser_data;
    logic        frame_sync;
    logic        underrun;
    logic        cfg_bad;

    int   n_vec = 0;
    int   n_bad = 0;
    int   fifo_idx = 0;
    int   avail_r = 0;
    logic fifo_clr = 1'b0;
    int   phase = 0;
    logic sel_fall = 1'b0;
    logic was_sel;
    logic done = 1'b0;

    always #2.5 clk = !clk;

    function automatic logic [31:0] wgen(input int i);
        logic [31:0] x;
        x = 32'(i + 1) * 32'h9E3779B9;
        return x ^ {x[15:0], x[31:16]};
    endfunction

    assign word_valid = (fifo_idx < avail_r);
    assign word_data  = wgen(fifo_idx);

    always @(posedge clk) begin
        if (fifo_clr) fifo_idx <= 0;
        else if (word_ready && word_valid) fifo_idx <= fifo_idx + 1;
    end

    tdm_serializer uut (.*);

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        was_sel = sel_fall ? fall_tick : rise_tick;
        phase = (phase + 1) % 4;
        rise_tick = (phase == 0);
        fall_tick = (phase == 2);
    endtask

    function automatic int ds_of(input int c);
        case (c)
            2: return 8;  3: return 10; 4: return 16;
            5: return 20; 6: return 24; 7: return 32;
            default: return 0;
        endcase
    endfunction

    task automatic run_case(input int frl, input int fsl, input bit early, input bit high,
                            input bit lfall, input int nb, input int scode, input int mask,
                            input int off, input int dcode, input bit mono, input int nframes,
                            input int avail, input bit midchange);
        int ds, w, lead_n, flen, total, k, k0, model_idx, p, f, pos, slot, b, idle_seen;
        logic [31:0] cur;
        logic e_sd, e_fs, e_ud, on, last_sd, last_fs;
        ds = ds_of(dcode);
        w = (scode == 0) ? ds : (scode == 1 ? 16 : 32);
        lead_n = early ? 1 : 0;
        flen = frl + 1;
        total = lead_n + nframes * flen;
        k0 = lead_n + (nframes - 1) * flen;
        step();
        cfg_frame_last = 9'(frl); cfg_sync_last = 9'(fsl); cfg_sync_early = early;
        cfg_sync_high = high; cfg_launch_fall = lfall; cfg_slot_last = 4'(nb);
        cfg_slot_code = 2'(scode); cfg_slot_mask = 16'(mask); cfg_first_off = 5'(off);
        cfg_size_code = 3'(dcode); cfg_mono = mono; sel_fall = lfall;
        fifo_clr = 1'b1; avail_r = avail;
        step();
        fifo_clr = 1'b0;
        repeat (8) step();
        chk(cfg_bad == 1'b0, "R10 legal config accepted", int'(cfg_bad), 0);
        enable = 1'b1;
        k = 0; cur = '0; model_idx = 0; last_sd = 1'b0; last_fs = !high;
        while (k < total) begin
            step();
            if (was_sel) begin
                e_ud = 1'b0; e_sd = 1'b0;
                if (k < lead_n) begin
                    e_fs = 1'b1;
                end else begin
                    p = k - lead_n; f = p / flen; pos = p % flen;
                    slot = pos / w; b = pos % w;
                    on = (slot <= nb) && mask[slot];
                    if (on && b == 0 && !(mono && nb == 1 && slot == 1)) begin
                        if (model_idx < avail) begin cur = wgen(model_idx); model_idx++; end
                        else begin cur = '0; e_ud = 1'b1; end
                    end
                    if (on && b >= off && (b - off) < ds) e_sd = cur[ds - 1 - (b - off)];
                    if (early) e_fs = (pos < fsl) || (pos == frl && f < nframes - 1);
                    else       e_fs = (pos <= fsl);
                end
                // R1 R2 frame timing, R5 R6 R7 R8 data placement, R3 polarity
                chk(ser_data == e_sd, "R5 R6 R7 R8 serial data bit", int'(ser_data), int'(e_sd));
                chk(frame_sync == (high ? e_fs : !e_fs), "R1 R2 R3 frame sync",
                    int'(frame_sync), int'(high ? e_fs : !e_fs));
                chk(underrun == e_ud, "R9 underrun pulse", int'(underrun), int'(e_ud));
                last_sd = ser_data; last_fs = frame_sync;
                if (k == k0) enable = 1'b0;
                if (midchange && k == 5) begin
                    cfg_slot_mask = '0; cfg_sync_high = !high; cfg_first_off = 5'd3; // R11
                end
                if (midchange && k == 20) begin
                    cfg_slot_mask = 16'(mask); cfg_sync_high = high; cfg_first_off = 5'(off);
                end
                k++;
            end else begin
                chk(ser_data == last_sd && frame_sync == last_fs, "R4 outputs hold off-tick",
                    int'({ser_data, frame_sync}), int'({last_sd, last_fs}));
                chk(underrun == 1'b0, "R9 underrun lasts one cycle", int'(underrun), 0);
            end
        end
        idle_seen = 0;
        while (idle_seen < 4) begin
            step();
            if (was_sel) begin
                idle_seen++;
                chk(ser_data == 1'b0, "R11 data quiet after stop", int'(ser_data), 0);
                chk(frame_sync == !high, "R11 sync inactive after stop", int'(frame_sync), int'(!high));
                chk(underrun == 1'b0, "R11 no underrun after stop", int'(underrun), 0);
            end
        end
        chk(fifo_idx == model_idx, "R6 R8 R12 words taken", fifo_idx, model_idx);
    endtask

    task automatic bad_case(input int dcode, input int scode);
        step();
        cfg_size_code = 3'(dcode); cfg_slot_code = 2'(scode);
        cfg_sync_high = 1'b1; cfg_launch_fall = 1'b0; sel_fall = 1'b0;
        cfg_slot_mask = 16'h3; cfg_slot_last = 4'd1; cfg_frame_last = 9'd31;
        fifo_clr = 1'b1; avail_r = 8;
        step();
        fifo_clr = 1'b0;
        repeat (4) step();
        enable = 1'b1;
        for (int i = 0; i < 60; i++) begin
            step();
            chk(cfg_bad == 1'b1, "R10 illegal config flagged", int'(cfg_bad), 1);
            chk(word_ready == 1'b0 && ser_data == 1'b0 && frame_sync == 1'b0,
                "R10 engine stays idle", int'({word_ready, ser_data, frame_sync}), 0);
        end
        enable = 1'b0;
        chk(fifo_idx == 0, "R10 no word taken", fifo_idx, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        step(); step();
        chk(ser_data == 1'b0, "reset data", int'(ser_data), 0);
        chk(frame_sync == 1'b0, "R3 reset sync level", int'(frame_sync), 0);
        chk(underrun == 1'b0 && word_ready == 1'b0, "R12 reset handshake",
            int'({underrun, word_ready}), 0);
        chk(cfg_bad == 1'b1, "R10 size code 0 rejected", int'(cfg_bad), 1);
        // I2S-like: 16-bit in 16-bit slots, early active-low half-frame sync
        run_case(31, 15, 1, 0, 0, 1, 0, 'h3, 0, 4, 0, 3, 64, 0);
        // left-justified 16 in 32-bit slots
        run_case(63, 31, 0, 1, 0, 1, 2, 'h3, 0, 4, 0, 2, 64, 0);
        // right-justified 20 in 32, launched on falling tick
        run_case(63, 31, 0, 1, 1, 1, 2, 'h3, 12, 5, 0, 2, 64, 0);
        // DSP short early sync, 4 x 8-bit slots, slot 2 masked, mid-run config change
        run_case(31, 0, 1, 1, 0, 3, 0, 'hB, 0, 2, 0, 3, 64, 1);
        // short sync on first bit, 10-bit in 16-bit slots, 8 trailing bits
        run_case(71, 0, 0, 1, 1, 3, 1, 'hF, 0, 3, 0, 2, 64, 0);
        // mono duplication
        run_case(31, 15, 0, 1, 0, 1, 0, 'h3, 0, 4, 1, 2, 64, 0);
        // underrun: 32-bit words, only three available
        run_case(63, 31, 0, 0, 0, 1, 2, 'h3, 0, 7, 0, 3, 3, 0);
        // illegal: 24-bit data in 16-bit slot, then size code 1
        bad_case(6, 1);
        bad_case(1, 2);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule